// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits on the synchronous side of a chip and runs an external asynchronous static RAM of 131,072 bytes. A client hands it one word at a time on a valid/ready handshake: a direction bit, a 17-bit address and, for stores, an 8-bit value. Loads come back on a registered data port marked by a one-cycle valid strobe. On the memory side the block drives active-low chip-select, output-enable and write-strobe lines, a held address bus, and a data bus split into an outgoing value, its drive enable and an incoming value.

Every analog interval (access time, write pulse width, data setup before the end of a write, bus release delay) is a picosecond parameter. Elaboration turns each one into a whole number of clock cycles by rounding up against the clock period. Between requests the chip select stays high, so the memory rests in standby. Output-enable stays high for the whole of every write, which allows the shorter write pulse. A store that follows a load waits out a release gap before the block drives the bus.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held, and whenever no request is in progress, chip-select, output-enable and write-strobe are all high, the data drive enable is low and `req_ready` is high.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the access completes, and each accepted store produces exactly one write to the memory.
- R3: A load holds chip-select and output-enable low, write-strobe high and the address steady for ACC_CYC+1 cycles, where ACC_CYC = ceil(T_ACC_PS/CLK_PS) (3 by default). `rd_valid` rises at the (ACC_CYC+1)-th rising edge after the accepting edge.
- R4: `rd_valid` is high for exactly one cycle per load.
- R5: Write-strobe goes low only while chip-select is low and output-enable is high. It stays low for PULSE_CYC consecutive cycles, where PULSE_CYC = max(ceil(T_WP_PS/CLK_PS), ceil(T_DS_PS/CLK_PS)) (2 by default).
- R6: Store data is driven and unchanged from at least one cycle before write-strobe falls until at least the cycle after it rises, and the address does not change over that span.
- R7: The data drive enable is never high while output-enable is low or while the memory may still be releasing the bus. A load returns the byte most recently stored at that address.
- R8: When a store follows a load, output-enable is high for at least TURN_CYC cycles, TURN_CYC = ceil(T_HZ_PS/CLK_PS) with a minimum of 1 (2 by default), before the drive enable rises.
- R9: Counting the clock periods after the accepting edge, write-strobe is first seen low in period 2 when the previous access was a store or there was none since reset, and in period TURN_CYC+2 when the previous access was a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client presents a request |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Value to store |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` |
| rd_data | output | 8 | Value returned by the last load |
| sram_ce_n | output | 1 | Memory chip-select, active low |
| sram_oe_n | output | 1 | Memory output-enable, active low |
| sram_we_n | output | 1 | Memory write-strobe, active low |
| sram_addr | output | 17 | Memory address bus |
| sram_dq_out | output | 8 | Value the controller places on the data bus |
| sram_dq_oe | output | 1 | Controller drives the data bus when high |
| sram_dq_in | input | 8 | Value seen on the data bus |

## Verification
The assertions assume that the data bus really goes quiet within TURN_CYC cycles of output-enable rising, and that a valid word reaches the bus within ACC_CYC cycles of the read strobes. They also assume the client keeps `req_write`, `req_addr` and `req_wdata` steady while `req_valid` waits on `req_ready`. The bench's memory model behaves exactly within those limits. It keeps driving for TURN_CYC cycles after a load ends, and it returns a junk byte until the read strobes have been held for ACC_CYC cycles. The client tasks change request fields only at falling edges and only while no request is pending.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ACCESS,
      ST_RD_CAPTURE,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_RECOVER,
      ST_TURN
   } ctl_state_e;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic dq_oe;
   } strobe_t;

   // Round an interval up to whole clock cycles, never below one.
   function automatic int unsigned ps_to_cyc(int unsigned t_ps, int unsigned clk_ps);
      int unsigned q;
      q = (t_ps + clk_ps - 1) / clk_ps;
      return (q < 1) ? 1 : q;
   endfunction

   function automatic int unsigned umax(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // Pin levels wanted in each controller state.
   function automatic strobe_t strobes_for(ctl_state_e s);
      strobe_t p;
      p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
      case (s)
         ST_RD_ACCESS, ST_RD_CAPTURE: begin
            p.ce_n = 1'b0;
            p.oe_n = 1'b0;
         end
         ST_WR_SETUP, ST_WR_RECOVER: begin
            p.ce_n  = 1'b0;
            p.dq_oe = 1'b1;
         end
         ST_WR_PULSE: begin
            p.ce_n  = 1'b0;
            p.we_n  = 1'b0;
            p.dq_oe = 1'b1;
         end
         default: ;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int unsigned ACC_CYC   = 3,
   parameter int unsigned PULSE_CYC = 2,
   parameter int unsigned TURN_CYC  = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_valid,
   input  logic    req_write,
   output logic    req_ready,
   output logic    accept,
   output logic    capture,
   output strobe_t strb
);

   localparam int unsigned CNT_MAX = umax(umax(ACC_CYC, PULSE_CYC), TURN_CYC);
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] ACC_LD   = CNT_W'(ACC_CYC - 1);
   localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);
   localparam int unsigned QW = $clog2(TURN_CYC + 1) + 1;
   localparam int unsigned WW = $clog2(PULSE_CYC + 1) + 1;

   ctl_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             last_rd_q, last_rd_d;
   strobe_t          strb_q;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready & req_valid;
   assign capture   = (state_q == ST_RD_CAPTURE);
   assign strb      = strb_q;

   always_comb begin
      state_d   = state_q;
      cnt_d     = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
      last_rd_d = last_rd_q;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               if (req_write) begin
                  last_rd_d = 1'b0;
                  if (last_rd_q) begin
                     state_d = ST_TURN;
                     cnt_d   = TURN_LD;
                  end else begin
                     state_d = ST_WR_SETUP;
                  end
               end else begin
                  last_rd_d = 1'b1;
                  state_d   = ST_RD_ACCESS;
                  cnt_d     = ACC_LD;
               end
            end
         end
         ST_RD_ACCESS:  if (cnt_q == '0) state_d = ST_RD_CAPTURE;
         ST_RD_CAPTURE: state_d = ST_IDLE;
         ST_TURN:       if (cnt_q == '0) state_d = ST_WR_SETUP;
         ST_WR_SETUP: begin
            state_d = ST_WR_PULSE;
            cnt_d   = PULSE_LD;
         end
         ST_WR_PULSE:   if (cnt_q == '0) state_d = ST_WR_RECOVER;
         ST_WR_RECOVER: state_d = ST_IDLE;
         default:       state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         last_rd_q <= 1'b0;
         strb_q    <= strobes_for(ST_IDLE);
      end else begin
         state_q   <= state_d;
         cnt_q     <= cnt_d;
         last_rd_q <= last_rd_d;
         strb_q    <= strobes_for(state_d);
      end
   end

   // Observers for the timing assertions.
   logic [QW-1:0] oe_quiet_q;
   logic [WW-1:0] we_len_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_quiet_q <= QW'(TURN_CYC);
         we_len_q   <= '0;
      end else begin
         if (!strb_q.oe_n)                   oe_quiet_q <= '0;
         else if (oe_quiet_q < QW'(TURN_CYC)) oe_quiet_q <= oe_quiet_q + 1'b1;
         if (!strb_q.we_n) begin
            if (we_len_q < WW'(PULSE_CYC + 1)) we_len_q <= we_len_q + 1'b1;
         end else begin
            we_len_q <= '0;
         end
      end
   end

   AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_q.we_n |-> !strb_q.ce_n);                                  // R5
   AST_WE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_q.we_n |-> strb_q.oe_n);                                   // R5
   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_q.we_n) |-> (we_len_q >= WW'(PULSE_CYC)));            // R5
   AST_DATA_UNDER_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_q.we_n |-> strb_q.dq_oe);                                  // R6
   AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_q.oe_n |-> !strb_q.dq_oe);                                 // R7
   AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_q.dq_oe) |-> (oe_quiet_q >= QW'(TURN_CYC)));          // R8
   AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (strb_q.ce_n && strb_q.we_n && !strb_q.dq_oe));   // R1

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] dq_out,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic              rvalid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q   <= '0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         rvalid_q <= capture;
         if (capture) rdata_q <= dq_in;
      end
   end

   assign mem_addr = addr_q;
   assign dq_out   = wdata_q;
   assign rd_valid = rvalid_q;
   assign rd_data  = rdata_q;

   AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_q |=> !rvalid_q);                                          // R4

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W   = 17,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CLK_PS   = 5000,
   parameter int unsigned T_ACC_PS = 12000,
   parameter int unsigned T_WP_PS  = 9000,
   parameter int unsigned T_DS_PS  = 9000,
   parameter int unsigned T_HZ_PS  = 6000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              sram_ce_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_in
);

   localparam int unsigned ACC_CYC   = ps_to_cyc(T_ACC_PS, CLK_PS);
   localparam int unsigned PULSE_CYC = umax(ps_to_cyc(T_WP_PS, CLK_PS),
                                            ps_to_cyc(T_DS_PS, CLK_PS));
   localparam int unsigned TURN_CYC  = ps_to_cyc(T_HZ_PS, CLK_PS);

   if (CLK_PS == 0) begin : g_bad_clk
      $error("asram_ctrl: CLK_PS must be non-zero");
   end
   if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr
      $error("asram_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("asram_ctrl: DATA_W must be positive");
   end

   logic    accept, capture;
   strobe_t strb;

   asram_seq #(
      .ACC_CYC  (ACC_CYC),
      .PULSE_CYC(PULSE_CYC),
      .TURN_CYC (TURN_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_write(req_write),
      .req_ready(req_ready),
      .accept   (accept),
      .capture  (capture),
      .strb     (strb)
   );

   asram_dpath #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_dpath (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .capture  (capture),
      .req_addr (req_addr),
      .req_wdata(req_wdata),
      .dq_in    (sram_dq_in),
      .mem_addr (sram_addr),
      .dq_out   (sram_dq_out),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   assign sram_ce_n  = strb.ce_n;
   assign sram_oe_n  = strb.oe_n;
   assign sram_we_n  = strb.we_n;
   assign sram_dq_oe = strb.dq_oe;

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));       // R3
   AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);                         // R2

endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;

   localparam int CLK_PS    = 5000;
   localparam int ACC_CYC   = (12000 + CLK_PS - 1) / CLK_PS;
   localparam int PULSE_CYC = (9000 + CLK_PS - 1) / CLK_PS;
   localparam int TURN_CYC  = (6000 + CLK_PS - 1) / CLK_PS;
   localparam int NADDR     = 36;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rd_valid;
   logic [7:0]  rd_data;
   logic        ce_n, oe_n, we_n, dq_oe;
   logic [16:0] sram_addr;
   logic [7:0]  dq_out, dq_in;

   always #2500ps clk = ~clk;

   asram_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
      .sram_addr(sram_addr), .sram_dq_out(dq_out), .sram_dq_oe(dq_oe),
      .sram_dq_in(dq_in)
   );

   int checks = 0, fails = 0, commits = 0, writes_sent = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural memory with bus-fight detection
   logic [7:0]  mem [logic [16:0]];
   logic [7:0]  mem_out = 8'hEE;
   int          hold = 0, acc = 0, wlen = 0;
   logic [16:0] prev_addr = '0, waddr = '0;
   logic [7:0]  wdat = '0, prev_dq = '0;
   logic        prev_dq_oe = 1'b0, prev_rdv = 1'b0;

   assign dq_in = dq_oe ? dq_out : mem_out;

   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit rd_act = !ce_n && !oe_n && we_n;
         if (dq_oe && (rd_act || hold > 0))
            check(0, "R7", "bus driven by both sides", hold, 0);
         if (rd_act && !(!prev_dq_oe && 1) && 0) ;
         acc = rd_act ? ((sram_addr == prev_addr && acc > 0) ? acc + 1 : 1) : 0;
         if (rd_act)
            mem_out = (acc >= ACC_CYC && mem.exists(sram_addr)) ? mem[sram_addr] : 8'h3C;
         else if (hold == 0)
            mem_out = 8'hEE;
         if (rd_act) hold = TURN_CYC;
         else if (hold > 0) hold--;
         if (!we_n) begin
            if (ce_n) check(0, "R5", "write strobe without chip select", ce_n, 0);
            if (!oe_n) check(0, "R5", "output enable low during write", oe_n, 1);
            if (!dq_oe) check(0, "R6", "data not driven under write strobe", dq_oe, 1);
            if (wlen == 0) begin
               if (!prev_dq_oe || prev_dq != dq_out)
                  check(0, "R6", "data not set up before strobe", prev_dq_oe, 1);
               waddr = sram_addr;
               wdat  = dq_out;
            end else if (dq_out != wdat || sram_addr != waddr) begin
               check(0, "R6", "data or address moved under strobe", dq_out, wdat);
            end
            wlen++;
         end else if (wlen > 0) begin
            check(wlen == PULSE_CYC, "R5", "write pulse cycles", wlen, PULSE_CYC);
            check(dq_oe && dq_out == wdat && !ce_n, "R6", "data hold after strobe",
                  dq_out, wdat);
            mem[waddr] = wdat;
            commits++;
            wlen = 0;
         end
         if (rd_valid && prev_rdv) check(0, "R4", "rd_valid longer than one cycle", 2, 1);
         prev_rdv   = rd_valid;
         prev_addr  = sram_addr;
         prev_dq_oe = dq_oe;
         prev_dq    = dq_out;
      end
   end

   // ---------------- stimulus helpers (entered and left at a falling edge)
   function automatic logic [16:0] addr_of(input int i);
      if (i == 0) return 17'h00000;
      if (i == 1) return 17'h1FFFF;
      if (i < 19) return 17'(1) << (i - 2);
      return ~(17'(1) << (i - 19));
   endfunction

   function automatic logic [7:0] pat(input logic [16:0] a, input int pass);
      return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ ((pass == 0) ? 8'h5A : 8'hC3);
   endfunction

   task automatic do_write(input logic [16:0] a, input logic [7:0] d, input int exp_lat);
      int k;
      req_write = 1'b1; req_addr = a; req_wdata = d; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      writes_sent++;
      check(req_ready == 1'b0, "R2", "ready low while busy", req_ready, 0);
      k = 1;
      while (we_n && k < 40) begin @(negedge clk); k++; end
      check(k == exp_lat, "R9", "write strobe latency", k, exp_lat);
      while (!req_ready) @(negedge clk);
   endtask

   task automatic do_read(input logic [16:0] a, input logic [7:0] exp_d);
      int k;
      req_write = 1'b0; req_addr = a; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready == 1'b0, "R2", "ready low while busy", req_ready, 0);
      k = 1;
      while (!rd_valid && k < 40) begin @(negedge clk); k++; end
      check(k == ACC_CYC + 2, "R3", "read valid latency", k, ACC_CYC + 2);
      check(rd_data == exp_d, "R7", "read data", rd_data, exp_d);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check({ce_n, oe_n, we_n, dq_oe, req_ready} == 5'b11101, "R1",
            "pins during reset", {ce_n, oe_n, we_n, dq_oe, req_ready}, 5'b11101);
      rst_n = 1'b1;
      @(negedge clk);
      check({ce_n, oe_n, we_n, dq_oe, req_ready, rd_valid} == 6'b111010, "R1",
            "pins after reset", {ce_n, oe_n, we_n, dq_oe, req_ready, rd_valid}, 6'b111010);

      // store sweep: back-to-back stores, no release gap
      for (int i = 0; i < NADDR; i++) do_write(addr_of(i), pat(addr_of(i), 0), 2);
      @(negedge clk);
      check({ce_n, oe_n, we_n, dq_oe, req_ready} == 5'b11101, "R1",
            "idle after stores", {ce_n, oe_n, we_n, dq_oe, req_ready}, 5'b11101);

      // load sweep
      for (int i = 0; i < NADDR; i++) do_read(addr_of(i), pat(addr_of(i), 0));

      // load, then store at once (needs release gap), then read back
      for (int i = 0; i < NADDR; i++) begin
         do_read(addr_of(i), pat(addr_of(i), 0));
         do_write(addr_of(i), pat(addr_of(i), 1), TURN_CYC + 2);
         do_read(addr_of(i), pat(addr_of(i), 1));
      end

      // store after store after a load sequence ends
      do_write(17'h0ABCD, 8'h99, TURN_CYC + 2);
      do_write(17'h0ABCD, 8'h66, 2);
      do_read(17'h0ABCD, 8'h66);

      repeat (3) @(negedge clk);
      check(commits == writes_sent, "R2", "one memory write per store", commits, writes_sent);
      check({ce_n, oe_n, we_n, dq_oe, req_ready} == 5'b11101, "R1",
            "idle at end", {ce_n, oe_n, we_n, dq_oe, req_ready}, 5'b11101);
      done = 1;
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         finish_run();
      end
   end

endmodule